// File: doc/BRIEF.md
# Dependency-Ordered Row Dispatcher

This block sits between a row-analysis stage and a compute array in a sparse spike-matrix engine. Each incoming task record describes one matrix row: its index, whether it reuses the result of another row (and which row), the mask of bits still to be computed, and the row's popcount. The block collects one tile of `ROWS` records and places them in sorted order. It then streams them to the compute stage. The issue order guarantees that every row named as a prefix leaves before any row that builds on it.

Storage is split into two banks. The producer fills one bank while the compute stage drains the other, so analysis of tile N+1 overlaps with compute on tile N. Sorting happens as records arrive. Each accepted record is placed straight into its ordered slot in one cycle by a parallel compare-and-shift. A bank is therefore ready to issue on the cycle after its last record lands.

Top module: `row_dispatcher`

## Requirements
- R1: Within a tile, tasks leave in non-decreasing order of the `in_pop` value they carried.
- R2: Tasks of a tile with equal popcount leave in strictly ascending row-index order.
- R3: When a task leaves with its prefix-valid bit set, the row named by its prefix index has already left earlier in the same tile. This holds for inputs whose prefix row has a lower popcount, or an equal popcount and a lower row index.
- R4: While one bank is draining, the other bank accepts a complete new tile. `in_ready` stays 1 even though the output is stalled.
- R5: When both banks hold complete tiles that are not yet fully issued, `in_ready` is 0 and no record is taken.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and every output field is held unchanged into the next cycle.
- R7: `out_last` is 1 exactly on the `ROWS`-th task issued from a bank, and 0 on the others.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: No task of a tile is issued until all `ROWS` records of that tile have been accepted.
- R10: Row index, prefix-valid, prefix index, suffix mask and popcount reach the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a task record |
| in_ready | output | 1 | Record is accepted on this edge |
| in_row | input | $clog2(ROWS) | Row index of the record |
| in_pfx_vld | input | 1 | Row reuses a prefix row |
| in_pfx_idx | input | $clog2(ROWS) | Index of the prefix row |
| in_mask | input | MASK_W | Suffix mask still to compute |
| in_pop | input | $clog2(MASK_W+1) | Popcount of the row, primary sort key |
| out_valid | output | 1 | A sorted task is offered |
| out_ready | input | 1 | Compute stage takes the task |
| out_row | output | $clog2(ROWS) | Row index |
| out_pfx_vld | output | 1 | Prefix-valid flag |
| out_pfx_idx | output | $clog2(ROWS) | Prefix row index |
| out_mask | output | MASK_W | Suffix mask |
| out_pop | output | $clog2(MASK_W+1) | Popcount |
| out_last | output | 1 | Final task of the bank being drained |

## Verification
The state that is hardest to reach is both banks full with the producer still pushing: the output has to stall for a whole tile while a second tile is fed in. The stimulus holds `out_ready` low from reset and sends one tile in two parts, checking that nothing is issued between the parts. It then checks that a second tile is still accepted and that the input stalls after it. After that, random back-pressure is applied across tiles with chained subset masks, all-equal popcounts and fully identical rows. These cover ties, prefix chains, and inputs that arrive in shuffled order.

// File: rtl/disp_pkg.sv
package disp_pkg;
  // a strictly precedes b in issue order: popcount first, then row index
  function automatic logic key_before(input logic [15:0] pop_a, input logic [15:0] row_a,
                                      input logic [15:0] pop_b, input logic [15:0] row_b);
    return (pop_a < pop_b) || ((pop_a == pop_b) && (row_a < row_b));
  endfunction
endpackage

// File: rtl/pp_select.sv
module pp_select (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= 1'b0;
    else if (flip) sel <= ~sel;
  end
endmodule

// File: rtl/sort_bank.sv
module sort_bank import disp_pkg::*; #(
  parameter int ROWS  = 8,
  parameter int ROW_W = 3,
  parameter int POP_W = 5,
  parameter int TW    = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_task,
  input  logic          rd_en,
  output logic          can_write,
  output logic          can_read,
  output logic          fill_final,
  output logic [TW-1:0] rd_task,
  output logic          rd_last
);
  localparam int CNT_W = $clog2(ROWS + 1);

  logic [TW-1:0]    slot [ROWS];
  logic [CNT_W-1:0] fill_cnt;
  logic [ROW_W-1:0] rd_ptr;
  logic             draining;
  logic [ROWS-1:0]  after_new;   // occupied slot whose key follows the new record
  logic [TW-1:0]    slot_nxt [ROWS];

  assign can_write  = !draining;
  assign can_read   = draining;
  assign fill_final = (fill_cnt == CNT_W'(ROWS - 1));
  assign rd_task    = slot[rd_ptr];
  assign rd_last    = (rd_ptr == ROW_W'(ROWS - 1));

  for (genvar i = 0; i < ROWS; i++) begin : g_slot
    assign after_new[i] = (CNT_W'(i) < fill_cnt) &&
      key_before(16'(wr_task[POP_W-1:0]), 16'(wr_task[TW-1 -: ROW_W]),
                 16'(slot[i][POP_W-1:0]), 16'(slot[i][TW-1 -: ROW_W]));
    if (i == 0) begin : g_head
      assign slot_nxt[i] = (after_new[0] || fill_cnt == '0) ? wr_task : slot[0];
    end else begin : g_body
      logic take_prev, ins_here;
      assign take_prev   = after_new[i-1];
      assign ins_here    = (after_new[i] || (fill_cnt == CNT_W'(i))) && !after_new[i-1];
      assign slot_nxt[i] = take_prev ? slot[i-1] : (ins_here ? wr_task : slot[i]);
    end
    always_ff @(posedge clk) begin
      if (wr_en && !draining) slot[i] <= slot_nxt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      rd_ptr   <= '0;
      draining <= 1'b0;
    end else if (!draining) begin
      if (wr_en) begin
        fill_cnt <= fill_cnt + 1'b1;
        if (fill_final) begin
          draining <= 1'b1;
          rd_ptr   <= '0;
        end
      end
    end else if (rd_en) begin
      if (rd_last) begin
        draining <= 1'b0;
        fill_cnt <= '0;
      end else begin
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/row_dispatcher.sv
module row_dispatcher #(
  parameter int ROWS   = 8,
  parameter int MASK_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [$clog2(ROWS)-1:0]      in_row,
  input  logic                         in_pfx_vld,
  input  logic [$clog2(ROWS)-1:0]      in_pfx_idx,
  input  logic [MASK_W-1:0]            in_mask,
  input  logic [$clog2(MASK_W+1)-1:0]  in_pop,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [$clog2(ROWS)-1:0]      out_row,
  output logic                         out_pfx_vld,
  output logic [$clog2(ROWS)-1:0]      out_pfx_idx,
  output logic [MASK_W-1:0]            out_mask,
  output logic [$clog2(MASK_W+1)-1:0]  out_pop,
  output logic                         out_last
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int POP_W = $clog2(MASK_W + 1);
  localparam int TW    = 2 * ROW_W + 1 + MASK_W + POP_W;

  // named internal events, observed by the checker
  logic          wsel, rsel;
  logic          wr_fire, rd_fire;
  logic [1:0]    bank_cw, bank_cr, bank_ff, bank_last;
  logic [TW-1:0] bank_task [2];
  logic [TW-1:0] in_task, out_task;

  assign in_task  = {in_row, in_pfx_vld, in_pfx_idx, in_mask, in_pop};
  assign in_ready = bank_cw[wsel];
  assign wr_fire  = in_valid && in_ready;
  assign out_valid = bank_cr[rsel];
  assign rd_fire  = out_valid && out_ready;
  assign out_task = bank_task[rsel];
  assign {out_row, out_pfx_vld, out_pfx_idx, out_mask, out_pop} = out_task;
  assign out_last = out_valid && bank_last[rsel];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    sort_bank #(.ROWS(ROWS), .ROW_W(ROW_W), .POP_W(POP_W), .TW(TW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_fire && (wsel == b[0])),
      .wr_task    (in_task),
      .rd_en      (rd_fire && (rsel == b[0])),
      .can_write  (bank_cw[b]),
      .can_read   (bank_cr[b]),
      .fill_final (bank_ff[b]),
      .rd_task    (bank_task[b]),
      .rd_last    (bank_last[b])
    );
  end

  pp_select u_wsel (.clk(clk), .rst_n(rst_n), .flip(wr_fire && bank_ff[wsel]), .sel(wsel));
  pp_select u_rsel (.clk(clk), .rst_n(rst_n), .flip(rd_fire && bank_last[rsel]), .sel(rsel));
endmodule

// File: rtl/disp_checker.sv
module disp_checker #(
  parameter int ROWS  = 8,
  parameter int ROW_W = 3,
  parameter int POP_W = 5,
  parameter int TW    = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             rd_fire,
  input logic [1:0]       bank_cr,
  input logic [TW-1:0]    out_task,
  input logic [ROW_W-1:0] out_row,
  input logic             out_pfx_vld,
  input logic [ROW_W-1:0] out_pfx_idx,
  input logic [POP_W-1:0] out_pop,
  input logic             out_last
);
  logic [POP_W-1:0] prev_pop;
  logic [ROW_W-1:0] prev_row;
  logic             have_prev;
  logic [ROWS-1:0]  issued;
  logic [ROW_W:0]   issue_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pop <= '0; prev_row <= '0; have_prev <= 1'b0; issued <= '0; issue_cnt <= '0;
    end else if (rd_fire) begin
      if (out_last) begin
        have_prev <= 1'b0; issued <= '0; issue_cnt <= '0;
      end else begin
        have_prev <= 1'b1; prev_pop <= out_pop; prev_row <= out_row;
        issued[out_row] <= 1'b1; issue_cnt <= issue_cnt + 1'b1;
      end
    end
  end

  p_pop_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && have_prev |-> out_pop >= prev_pop);
  p_tie_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && have_prev && out_pop == prev_pop |-> out_row > prev_row);
  p_prefix_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && out_pfx_vld |-> issued[out_pfx_idx]);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank_cr) |-> !in_ready);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_task));
  p_tile_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (issue_cnt == (ROW_W+1)'(ROWS - 1))));
endmodule

bind row_dispatcher disp_checker #(.ROWS(ROWS), .ROW_W(ROW_W), .POP_W(POP_W), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .rd_fire(rd_fire), .bank_cr(bank_cr), .out_task(out_task), .out_row(out_row),
  .out_pfx_vld(out_pfx_vld), .out_pfx_idx(out_pfx_idx), .out_pop(out_pop), .out_last(out_last)
);

// File: tb/row_dispatcher_tb.sv
module row_dispatcher_tb;
  localparam int ROWS = 8;
  localparam int MW   = 16;
  localparam int RW   = $clog2(ROWS);
  localparam int PW   = $clog2(MW + 1);
  localparam int EW   = 2 * RW + 1 + MW + PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic          in_valid = 1'b0, in_ready;
  logic [RW-1:0] in_row = '0, in_pfx_idx = '0;
  logic          in_pfx_vld = 1'b0;
  logic [MW-1:0] in_mask = '0;
  logic [PW-1:0] in_pop = '0;
  logic          out_valid, out_ready = 1'b0, out_pfx_vld, out_last;
  logic [RW-1:0] out_row, out_pfx_idx;
  logic [MW-1:0] out_mask;
  logic [PW-1:0] out_pop;

  row_dispatcher #(.ROWS(ROWS), .MASK_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
    .in_pfx_vld(in_pfx_vld), .in_pfx_idx(in_pfx_idx), .in_mask(in_mask), .in_pop(in_pop),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_pfx_vld(out_pfx_vld),
    .out_pfx_idx(out_pfx_idx), .out_mask(out_mask), .out_pop(out_pop), .out_last(out_last));

  int checks = 0, fails = 0, cyc = 0, rdy_mode = 2, pos = 0;
  logic [EW-1:0] exp_q [$];
  logic [ROWS-1:0] seen = '0;
  logic held = 1'b0;
  logic [EW-1:0] held_bus = '0;
  logic [MW-1:0] tm [ROWS];
  logic [RW-1:0] tpi [ROWS];
  logic          tpv [ROWS];
  int            send_ord [ROWS];

  function automatic logic [EW-1:0] pack(int r);
    return {RW'(r), tpv[r], tpi[r], tm[r], PW'($countones(tm[r]))};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // build a tile, push the expected issue order, prepare a shuffled send order
  task automatic gen_tile(input int mode);
    for (int k = 0; k < ROWS; k++) begin
      if (mode == 2) tm[k] = (k == 0) ? MW'($urandom) : tm[0];
      else if (mode == 1) begin
        tm[k] = '0;
        while ($countones(tm[k]) < 4) tm[k][$urandom % MW] = 1'b1;
      end else if (k > 0 && ($urandom % 2) == 1)
        tm[k] = tm[$urandom % k] | (MW'($urandom) & MW'($urandom) & MW'($urandom));
      else tm[k] = MW'($urandom) & MW'($urandom);
    end
    for (int r = 0; r < ROWS; r++) begin
      int best = -1;
      for (int j = 0; j < ROWS; j++) begin
        int pj = $countones(tm[j]), pr = $countones(tm[r]);
        if (j != r && (tm[j] & ~tm[r]) == '0 && (pj < pr || j < r))
          if (best < 0 || pj > $countones(tm[best])) best = j;
      end
      tpv[r] = (best >= 0);
      tpi[r] = (best >= 0) ? RW'(best) : '0;
    end
    begin
      bit used [ROWS];
      for (int k = 0; k < ROWS; k++) used[k] = 1'b0;
      for (int n = 0; n < ROWS; n++) begin
        int pick = -1;
        for (int j = 0; j < ROWS; j++)
          if (!used[j] && (pick < 0 || $countones(tm[j]) * ROWS + j < $countones(tm[pick]) * ROWS + pick))
            pick = j;
        used[pick] = 1'b1;
        exp_q.push_back(pack(pick));
      end
    end
    for (int k = 0; k < ROWS; k++) send_ord[k] = k;
    for (int k = ROWS - 1; k > 0; k--) begin
      int j = $urandom % (k + 1);
      int t = send_ord[k];
      send_ord[k] = send_ord[j]; send_ord[j] = t;
    end
  endtask

  task automatic send_range(input int lo, input int hi);
    for (int k = lo; k <= hi; k++) begin
      int r = send_ord[k];
      @(negedge clk);
      in_valid = 1'b1;
      {in_row, in_pfx_vld, in_pfx_idx, in_mask, in_pop} = pack(r);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      logic r;
      logic [EW-1:0] bus, e;
      cyc++;
      if (cyc > 100000) begin chk(1'b0, "watchdog", cyc, 0); report(); end
      bus = {out_row, out_pfx_vld, out_pfx_idx, out_mask, out_pop};
      if (held) chk(out_valid && bus == held_bus, "R6 hold", bus, held_bus);
      r = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (($urandom % 3) != 0) : 1'b0;
      out_ready = r;
      if (out_valid && r) begin
        if (exp_q.size() == 0) chk(1'b0, "R1 R2 R10 unexpected task", bus, 0);
        else begin
          e = exp_q.pop_front();
          chk(bus == e, "R1 R2 R10 order/content", bus, e);
        end
        chk(out_last == (pos == ROWS - 1), "R7 last flag", out_last, pos == ROWS - 1);
        if (out_pfx_vld) chk(seen[out_pfx_idx], "R3 prefix issued first", out_pfx_idx, seen);
        seen[out_row] = 1'b1;
        if (pos == ROWS - 1) begin pos = 0; seen = '0; end else pos++;
      end
      held = out_valid && !r;
      held_bus = bus;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R8 idle out_valid", out_valid, 0);
    // partial fill: nothing may issue
    gen_tile(0);
    send_range(0, 4);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 partial tile issued", out_valid, 0);
    send_range(5, ROWS - 1);
    chk(out_valid == 1'b1, "R9 full tile not offered", out_valid, 1);
    chk(in_ready == 1'b1, "R4 second bank not free", in_ready, 1);
    // fill second bank while first stalls
    gen_tile(1);
    send_range(0, ROWS - 1);
    chk(in_ready == 1'b0, "R5 both banks full", in_ready, 0);
    chk(out_valid == 1'b1, "R5 output lost", out_valid, 1);
    // third tile waits for a free bank
    rdy_mode = 1;
    gen_tile(2);
    send_range(0, ROWS - 1);
    for (int t = 0; t < 12; t++) begin
      gen_tile(t % 3);
      send_range(0, ROWS - 1);
    end
    rdy_mode = 0;
    gen_tile(0);
    send_range(0, ROWS - 1);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R7 drained", out_valid, 0);
    report();
  end
endmodule